// File: doc/BRIEF.md
# Extender Sublayer Management Register Bank

This block is the management register file of a four-lane 10G extender sublayer. A host reaches it through a plain synchronous port: one cycle of `wr_en` or `rd_en` with a 16-bit register address, 16-bit write data, and a registered 16-bit read word. The block drives the sublayer's control settings: a self-timed soft reset, loopback, power-down, and the test-pattern enable and select. It reports live lane synchronisation and alignment.

Transmit and receive fault indications are caught in sticky bits. They stay set until the register that holds them is read, or until a management-disabled configuration pin is pulsed. A read returns a sticky bit as it stood before the clear. A fault that is still asserted during the read keeps its bit set. A summary fault bit is the OR of the two sticky bits.

Register map (full 16-bit address compare): control at 0x0000, status one at 0x0001, status two at 0x0002, lane status at 0x0003, test-pattern control at 0x0004. All other addresses are unmapped.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: Writing the control register with bit 15 set raises `soft_rst` and control bit 15 for exactly SRST_CYCLES cycles (default 4), after which both return to 0 without further writes.
- R2: Control bit 14 (loopback, drives `loopback`) and bit 11 (power-down, drives `power_down`) are read/write and reset to 0.
- R3: Control bit 13 always reads 1; control bits 12, 10..0 always read 0; writes to them have no effect, so a freshly reset control register reads 0x2000.
- R4: Status two bit 11 (transmit fault) and bit 10 (receive fault) are set in the cycle after `tx_fault_in` / `rx_fault_in` is sampled high, and stay set while nothing clears them.
- R5: A read of status two returns the sticky fault bits as they were before the read and then clears each one, unless its fault input is high in the cycle of that read, in which case it stays set.
- R6: Status one bit 7 reads 1 when either sticky fault bit is 1; all other status one bits read 0, and reading status one clears nothing.
- R7: Status two bits 15:14 always read binary 10; its remaining bits other than 11 and 10 read 0.
- R8: The lane status register shows `lanes_aligned` in bit 12, a constant 1 in bit 11, `lane_sync[3:0]` in bits 3:0, and 0 elsewhere.
- R9: While `mgmt_en` is 0, a rising edge on `flt_clr_cfg` clears both sticky fault bits; a steady high level does not clear them; with `mgmt_en` at 1 the pin has no effect.
- R10: The test-pattern register holds the enable in bit 2 (drives `tp_enable`) and the select in bits 1:0 (drives `tp_select`), read/write, reset to 0; its other bits read 0.
- R11: Reading an unmapped address returns 0x0000; writes to status one, status two, lane status or unmapped addresses change no register.
- R12: `rdata` is loaded at the clock edge that samples `rd_en`, with the register contents at that edge, and holds its value while `rd_en` is low; it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| lane_sync | input | NUM_LANES | Per-lane synchronisation flags, lane 0 in bit 0 |
| lanes_aligned | input | 1 | All lanes aligned |
| tx_fault_in | input | 1 | Transmit fault indication |
| rx_fault_in | input | 1 | Receive fault indication |
| mgmt_en | input | 1 | 1 when register access owns the configuration |
| flt_clr_cfg | input | 1 | Configuration pin; rising edge clears faults when mgmt_en is 0 |
| soft_rst | output | 1 | Self-clearing soft reset |
| loopback | output | 1 | Loopback enable |
| power_down | output | 1 | Power-down select |
| tp_enable | output | 1 | Test-pattern enable |
| tp_select | output | 2 | Test-pattern select |

## Verification
A write takes effect at the edge that samples `wr_en`. The control outputs are therefore valid one cycle later. A read word appears on `rdata` one cycle after `rd_en`. A fault input sampled at one edge is visible to a read strobed at the next edge.

The bench drives every input on the falling edge and samples on the following falling edge. Each register access therefore spans exactly one rising edge. The soft reset pulse is counted at falling edges, so its length can be compared with SRST_CYCLES. The clear rules need precise timing, and the sequences are ordered for that: the held-fault read, the post-clear read, and the level-versus-edge pin test each place the fault or pin change one edge before or at the read.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;

    localparam int AW = 16;
    localparam int DW = 16;

    localparam logic [AW-1:0] ADDR_CTRL  = 16'h0000;
    localparam logic [AW-1:0] ADDR_STAT1 = 16'h0001;
    localparam logic [AW-1:0] ADDR_STAT2 = 16'h0002;
    localparam logic [AW-1:0] ADDR_LANE  = 16'h0003;
    localparam logic [AW-1:0] ADDR_TPAT  = 16'h0004;

    localparam int B_SRST   = 15;
    localparam int B_LPBK   = 14;
    localparam int B_SPEED  = 13;
    localparam int B_PWDN   = 11;
    localparam int B_FLTSUM = 7;
    localparam int B_TXF    = 11;
    localparam int B_RXF    = 10;
    localparam int B_ALIGN  = 12;
    localparam int B_TPABLE = 11;
    localparam int B_TPEN   = 2;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT1,
        SEL_STAT2,
        SEL_LANE,
        SEL_TPAT,
        SEL_NONE
    } rsel_e;

    typedef struct packed {
        logic       srst;
        logic       loopback;
        logic       pwrdn;
        logic       tp_en;
        logic [1:0] tp_sel;
    } ctrl_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } fault_t;

    function automatic rsel_e decode_addr(input logic [AW-1:0] a);
        rsel_e s;
        case (a)
            ADDR_CTRL:  s = SEL_CTRL;
            ADDR_STAT1: s = SEL_STAT1;
            ADDR_STAT2: s = SEL_STAT2;
            ADDR_LANE:  s = SEL_LANE;
            ADDR_TPAT:  s = SEL_TPAT;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input ctrl_t c);
        logic [DW-1:0] w;
        w          = '0;
        w[B_SRST]  = c.srst;
        w[B_LPBK]  = c.loopback;
        w[B_SPEED] = 1'b1;
        w[B_PWDN]  = c.pwrdn;
        return w;
    endfunction

    function automatic logic [DW-1:0] stat2_word(input fault_t f);
        logic [DW-1:0] w;
        w        = '0;
        w[15:14] = 2'b10;
        w[B_TXF] = f.tx;
        w[B_RXF] = f.rx;
        return w;
    endfunction

    function automatic logic [DW-1:0] tpat_word(input ctrl_t c);
        logic [DW-1:0] w;
        w         = '0;
        w[B_TPEN] = c.tp_en;
        w[1:0]    = c.tp_sel;
        return w;
    endfunction

endpackage

// File: rtl/pcs_ctrl_regs.sv
module pcs_ctrl_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int SRST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_tpat,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl
);
    localparam int CW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(SRST_CYCLES - 1);

    ctrl_t         ctrl_q;
    logic [CW-1:0] srst_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            srst_cnt <= '0;
        end else begin
            if (wr_ctrl && wdata[B_SRST]) begin
                ctrl_q.srst <= 1'b1;
                srst_cnt    <= CNT_LOAD;
            end else if (ctrl_q.srst) begin
                if (srst_cnt == '0) begin
                    ctrl_q.srst <= 1'b0;
                end else begin
                    srst_cnt <= srst_cnt - 1'b1;
                end
            end
            if (wr_ctrl) begin
                ctrl_q.loopback <= wdata[B_LPBK];
                ctrl_q.pwrdn    <= wdata[B_PWDN];
            end
            if (wr_tpat) begin
                ctrl_q.tp_en  <= wdata[B_TPEN];
                ctrl_q.tp_sel <= wdata[1:0];
            end
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pcs_fault_latch.sv
module pcs_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic clr,
    output logic sticky
);
    logic sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= fault_in | (sticky_q & ~clr);
        end
    end

    assign sticky = sticky_q;

endmodule

// File: rtl/pcs_rd_mux.sv
module pcs_rd_mux
    import pcs_mgmt_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  rsel_e                sel,
    input  ctrl_t                ctrl,
    input  fault_t               flt,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic                 lanes_aligned,
    output logic [DW-1:0]        word
);
    always_comb begin
        word = '0;
        case (sel)
            SEL_CTRL:  word = ctrl_word(ctrl);
            SEL_STAT1: word[B_FLTSUM] = flt.tx | flt.rx;
            SEL_STAT2: word = stat2_word(flt);
            SEL_LANE: begin
                word[B_ALIGN]       = lanes_aligned;
                word[B_TPABLE]      = 1'b1;
                word[NUM_LANES-1:0] = lane_sync;
            end
            SEL_TPAT:  word = tpat_word(ctrl);
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int SRST_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [15:0]          addr,
    input  logic [15:0]          wdata,
    output logic [15:0]          rdata,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic                 lanes_aligned,
    input  logic                 tx_fault_in,
    input  logic                 rx_fault_in,
    input  logic                 mgmt_en,
    input  logic                 flt_clr_cfg,
    output logic                 soft_rst,
    output logic                 loopback,
    output logic                 power_down,
    output logic                 tp_enable,
    output logic [1:0]           tp_select
);
    localparam int NFLT = 2;

    rsel_e         sel;
    ctrl_t         ctrl;
    fault_t        flt;
    logic [NFLT-1:0] flt_lat;
    logic [NFLT-1:0] flt_src;
    logic          cfg_q;
    logic          cfg_rise_clr;
    logic          rd_clr;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rdata_q;

    assign sel = decode_addr(addr);

    pcs_ctrl_regs #(.SRST_CYCLES(SRST_CYCLES)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_en && (sel == SEL_CTRL)),
        .wr_tpat (wr_en && (sel == SEL_TPAT)),
        .wdata   (wdata),
        .ctrl    (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= 1'b0;
        end else begin
            cfg_q <= flt_clr_cfg;
        end
    end

    assign cfg_rise_clr = !mgmt_en && flt_clr_cfg && !cfg_q;
    assign rd_clr       = rd_en && (sel == SEL_STAT2);
    assign flt_src      = {rx_fault_in, tx_fault_in};

    generate
        for (genvar i = 0; i < NFLT; i++) begin : g_flt
            pcs_fault_latch lat_i (
                .clk      (clk),
                .rst      (rst),
                .fault_in (flt_src[i]),
                .clr      (rd_clr | cfg_rise_clr),
                .sticky   (flt_lat[i])
            );
        end
    endgenerate

    assign flt.tx = flt_lat[0];
    assign flt.rx = flt_lat[1];

    pcs_rd_mux #(.NUM_LANES(NUM_LANES)) mux_i (
        .sel           (sel),
        .ctrl          (ctrl),
        .flt           (flt),
        .lane_sync     (lane_sync),
        .lanes_aligned (lanes_aligned),
        .word          (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_word;
        end
    end

    assign rdata      = rdata_q;
    assign soft_rst   = ctrl.srst;
    assign loopback   = ctrl.loopback;
    assign power_down = ctrl.pwrdn;
    assign tp_enable  = ctrl.tp_en;
    assign tp_select  = ctrl.tp_sel;

endmodule

// File: rtl/pcs_mgmt_regs_chk.sv
module pcs_mgmt_regs_chk #(
    parameter int NUM_LANES   = 4,
    parameter int SRST_CYCLES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic [15:0]          addr,
    input logic [15:0]          rdata,
    input logic                 tx_fault_in,
    input logic                 rx_fault_in,
    input logic [1:0]           flt_lat,
    input logic                 soft_rst,
    input logic [NUM_LANES-1:0] lane_sync
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (soft_rst) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_srst_len_R1: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (hi_cnt < SRST_CYCLES));

    assert_tx_latch_R4: assert property (@(posedge clk) disable iff (rst)
        tx_fault_in |=> flt_lat[0]);

    assert_rx_latch_R4: assert property (@(posedge clk) disable iff (rst)
        rx_fault_in |=> flt_lat[1]);

    assert_summary_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 16'h0001) |=> (rdata[7] == ($past(flt_lat[0]) | $past(flt_lat[1]))));

    assert_devpres_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 16'h0002) |=> (rdata[15:14] == 2'b10));

    assert_lane_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 16'h0003) |=> (rdata[11] && rdata[NUM_LANES-1:0] == $past(lane_sync)));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > 16'h0004) |=> (rdata == 16'h0000));

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind pcs_mgmt_regs pcs_mgmt_regs_chk #(
    .NUM_LANES   (NUM_LANES),
    .SRST_CYCLES (SRST_CYCLES)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .addr        (addr),
    .rdata       (rdata),
    .tx_fault_in (tx_fault_in),
    .rx_fault_in (rx_fault_in),
    .flt_lat     (flt_lat),
    .soft_rst    (soft_rst),
    .lane_sync   (lane_sync)
);

// File: tb/pcs_mgmt_regs_tb_top.sv
module pcs_mgmt_regs_tb_top;
    localparam int NL   = 4;
    localparam int SRST = 4;
    localparam int WD   = 100000;

    localparam logic [15:0] A_CTRL  = 16'h0000;
    localparam logic [15:0] A_STAT1 = 16'h0001;
    localparam logic [15:0] A_STAT2 = 16'h0002;
    localparam logic [15:0] A_LANE  = 16'h0003;
    localparam logic [15:0] A_TPAT  = 16'h0004;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [15:0]   addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [NL-1:0] lane_sync = '0;
    logic          lanes_aligned = 1'b0;
    logic          tx_fault_in = 1'b0;
    logic          rx_fault_in = 1'b0;
    logic          mgmt_en = 1'b1;
    logic          flt_clr_cfg = 1'b0;
    logic          soft_rst;
    logic          loopback;
    logic          power_down;
    logic          tp_enable;
    logic [1:0]    tp_select;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pcs_mgmt_regs #(.NUM_LANES(NL), .SRST_CYCLES(SRST)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lane_sync(lane_sync),
        .lanes_aligned(lanes_aligned), .tx_fault_in(tx_fault_in),
        .rx_fault_in(rx_fault_in), .mgmt_en(mgmt_en), .flt_clr_cfg(flt_clr_cfg),
        .soft_rst(soft_rst), .loopback(loopback), .power_down(power_down),
        .tp_enable(tp_enable), .tp_select(tp_select)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_fault_in = 1'b1;
        @(negedge clk); tx_fault_in = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_fault_in = 1'b1;
        @(negedge clk); rx_fault_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R12 rdata reset", rdata, 16'h0000);
        check("R2 outputs reset", {15'd0, loopback | power_down | soft_rst}, 16'h0000);
        rd(A_CTRL, d);  check("R3 ctrl reset value", d, 16'h2000);
        rd(A_TPAT, d);  check("R10 tpat reset value", d, 16'h0000);
        rd(A_STAT1, d); check("R6 stat1 reset value", d, 16'h0000);
        rd(A_STAT2, d); check("R7 stat2 reset value", d, 16'h8000);
    endtask

    task automatic t_ctrl_rw();
        logic [15:0] d;
        wr(A_CTRL, 16'h4800);
        check("R2 loopback/pwrdn outputs", {14'd0, loopback, power_down}, 16'h0003);
        rd(A_CTRL, d); check("R2 ctrl readback", d, 16'h6800);
        wr(A_CTRL, 16'h37FF);
        check("R2 outputs cleared", {14'd0, loopback, power_down}, 16'h0000);
        rd(A_CTRL, d); check("R3 reserved ignored", d, 16'h2000);
    endtask

    task automatic t_srst();
        logic [15:0] d;
        int cnt;
        wr(A_CTRL, 16'h8000);
        cnt = 0;
        while (soft_rst && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
        check("R1 soft reset length", 16'(cnt), 16'(SRST));
        rd(A_CTRL, d); check("R1 ctrl after self-clear", d, 16'h2000);
        wr(A_CTRL, 16'h8000);
        rd(A_CTRL, d); check("R1 bit15 reads 1 while active", d, 16'hA000);
        repeat (10) @(negedge clk);
        check("R1 soft_rst low later", {15'd0, soft_rst}, 16'h0000);
    endtask

    task automatic t_fault_latch();
        logic [15:0] d;
        pulse_tx();
        rd(A_STAT1, d); check("R6 summary set by tx", d, 16'h0080);
        rd(A_STAT2, d); check("R4 tx sticky", d, 16'h8800);
        rd(A_STAT2, d); check("R5 tx cleared by read", d, 16'h8000);
        rd(A_STAT1, d); check("R6 summary clear", d, 16'h0000);
    endtask

    task automatic t_fault_persist();
        logic [15:0] d;
        @(negedge clk); rx_fault_in = 1'b1;
        rd(A_STAT2, d); check("R4 rx sticky", d, 16'h8400);
        rx_fault_in = 1'b0;
        rd(A_STAT2, d); check("R5 fault at read keeps bit", d, 16'h8400);
        rd(A_STAT2, d); check("R5 cleared after fault gone", d, 16'h8000);
    endtask

    task automatic t_cfg_clear();
        logic [15:0] d;
        pulse_tx();
        @(negedge clk); flt_clr_cfg = 1'b1;
        @(negedge clk); flt_clr_cfg = 1'b0;
        rd(A_STAT1, d); check("R9 pin ignored when mgmt_en=1", d, 16'h0080);
        @(negedge clk); mgmt_en = 1'b0; flt_clr_cfg = 1'b1;
        @(negedge clk);
        rd(A_STAT1, d); check("R9 rising edge clears", d, 16'h0000);
        pulse_rx();
        rd(A_STAT1, d); check("R9 high level does not clear", d, 16'h0080);
        rd(A_STAT2, d); check("R9 rx held at level", d, 16'h8400);
        @(negedge clk); flt_clr_cfg = 1'b0; mgmt_en = 1'b1;
    endtask

    task automatic t_lane();
        logic [15:0] d;
        @(negedge clk); lane_sync = 4'b1010; lanes_aligned = 1'b1;
        rd(A_LANE, d); check("R8 lane status A", d, 16'h180A);
        @(negedge clk); lane_sync = 4'b0101; lanes_aligned = 1'b0;
        rd(A_LANE, d); check("R8 lane status B", d, 16'h0805);
    endtask

    task automatic t_tpat();
        logic [15:0] d;
        wr(A_TPAT, 16'h0006);
        check("R10 tp outputs", {13'd0, tp_enable, tp_select}, 16'h0006);
        rd(A_TPAT, d); check("R10 tpat readback", d, 16'h0006);
        wr(A_TPAT, 16'hFFFF);
        rd(A_TPAT, d); check("R10 tpat masked", d, 16'h0007);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        rd(16'h0055, d); check("R11 unmapped read", d, 16'h0000);
        rd(16'h1003, d); check("R11 unmapped high address", d, 16'h0000);
        wr(A_STAT1, 16'hFFFF);
        rd(A_STAT1, d); check("R11 stat1 write ignored", d, 16'h0000);
        wr(A_STAT2, 16'hFFFF);
        rd(A_STAT2, d); check("R11 stat2 write ignored", d, 16'h8000);
        wr(A_LANE, 16'hFFFF);
        rd(A_LANE, d); check("R11 lane write ignored", d, 16'h0805);
        wr(16'h0100, 16'hFFFF);
        rd(A_CTRL, d); check("R11 unmapped write ctrl", d, 16'h2000);
        rd(A_TPAT, d); check("R11 unmapped write tpat", d, 16'h0007);
    endtask

    task automatic t_rd_hold();
        logic [15:0] d;
        rd(A_LANE, d);
        @(negedge clk); lane_sync = 4'b1111; lanes_aligned = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 rdata holds", rdata, 16'h0805);
        rd(A_LANE, d); check("R12 new read updates", d, 16'h180F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_rw();
        t_srst();
        t_fault_latch();
        t_fault_persist();
        t_cfg_clear();
        t_lane();
        t_tpat();
        t_unmapped();
        t_rd_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule